// File: doc/BRIEF.md
# Three-Wire Addressed Register Port

This block is a slave serial port that a host controller reaches over three lines: a framing strobe, a serial clock and a data line. Each frame carries an 8-bit address and then 24 data bits, both sent least significant bit first. Two addresses select writable 24-bit control registers, whose contents go in parallel to the rest of the chip. Two other addresses select read-only 24-bit status words, which are built from the status inputs.

A write frame loads the data into the addressed control register only when the frame ends. A read frame takes a parallel snapshot of the selected status word on the clock fall that follows the eighth address bit. The word is then shifted out one bit per falling edge, with a separate enable that controls the data pad's tristate driver. The three serial lines are synchronised into the block clock domain before use.

Between frames the strobe is low and the serial clock is high. A frame is the interval in which the strobe is high.

Top module: `tri_wire_regport`

## Requirements
- R1: After reset, cfg_a holds 0x0F0000: bits 16 to 19, the reference code, are ones, which means standby, and all other bits are zero. cfg_b holds zero and ser_dout_en is low.
- R2: While ser_strobe is high, ser_din is sampled on every rising ser_clk edge. Sampled bit k for k below 8 is address bit k. Bit 8+j for j below 24 is data bit j.
- R3: When ser_strobe falls after exactly 32 or more sampled bits, address 0xD0 loads the data into cfg_a and address 0xD2 loads it into cfg_b. Neither register changes at any other moment.
- R4: A frame that ends with fewer than 32 sampled bits changes no register.
- R5: Bits sampled after the 32nd in one frame are discarded, so the committed data are the first 24 data bits.
- R6: A frame whose address is not 0xD0 or 0xD2 changes no register. When the address is also not 0xD1 or 0xD3, ser_dout_en stays low for the whole frame.
- R7: For address 0xD1, the word is captured on the first falling ser_clk edge after the eighth address bit. Its bits 0 to 19 are gc_count, bit 20 is gc_over, bit 21 is gc_busy, and bits 22 to 23 are zero. Word bit k appears on ser_dout after falling edge 9+k.
- R8: For address 0xD3, the captured word has bit 0 = lk_enable, bit 1 = lk_unlock, bits 2 to 4 = lk_phase[0..2], bits 5 to 9 = zero, bits 10 to 18 = cfg_b[10..18], and bits 19 to 23 = pin_in[0..4].
- R9: ser_dout_en goes high at the capture edge of a read frame. It goes low at the 32nd rising ser_clk edge or at the end of the frame, whichever comes first, and it is low in write frames.
- R10: Each output responds to a serial line edge exactly SYNC_STAGES+1 clk cycles after that edge.
- R11: Status inputs that change after the capture do not alter the bits shifted out in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_strobe | input | 1 | Frame strobe, high during a frame |
| ser_clk | input | 1 | Serial clock, idle high |
| ser_din | input | 1 | Serial data from the pad |
| ser_dout | output | 1 | Serial read data to the pad |
| ser_dout_en | output | 1 | Enable for the pad's tristate driver |
| cfg_a | output | 24 | Control register at address 0xD0 |
| cfg_b | output | 24 | Control register at address 0xD2 |
| gc_count | input | 20 | Count value for the 0xD1 word |
| gc_over | input | 1 | Count overflow flag |
| gc_busy | input | 1 | Count busy flag |
| lk_enable | input | 1 | Lock-detect valid flag |
| lk_unlock | input | 1 | Unlock flag |
| lk_phase | input | 3 | Phase error code |
| pin_in | input | 5 | Sampled general pin inputs |

## Verification
The bench builds the block with SYNC_STAGES = 2 and the default address values. This gives a fixed three-cycle path from a line edge to an output, which the reference model follows by delaying its expected values by three clocks before comparing them on every clock. With the serial clock run at eight block clocks per bit, every frame length is reachable: short frames, aborted reads, frames that overrun 32 bits, and status changes after the capture edge.

// File: rtl/trw_pkg.sv
// Shared widths, field positions and reset values for the three-wire register port.
// Assumes a fixed 8-bit address and 24-bit data word per frame.
package trw_pkg;
    localparam int ADDR_W     = 8;
    localparam int WORD_W     = 24;
    localparam int FRAME_BITS = ADDR_W + WORD_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    // Control-word fields that other blocks decode
    localparam int REF_LSB = 16;
    localparam int REF_W   = 4;
    localparam int DIR_LSB = 10;
    localparam int DIR_W   = 5;
    localparam int OUT_W   = 4;

    // Status-word fields
    localparam int CNT_FLD_W = 20;
    localparam int PE_W      = 3;
    localparam int PIN_W     = 5;
    localparam int CNT_PAD_W = WORD_W - CNT_FLD_W - 2;
    localparam int LK_GAP_W  = WORD_W - PIN_W - OUT_W - DIR_W - PE_W - 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam word_t CFG_A_RST = word_t'(((1 << REF_W) - 1) << REF_LSB);
    localparam word_t CFG_B_RST = '0;
endpackage

// File: rtl/trw_sync_edge.sv
// Synchroniser plus edge detector for a bundle of asynchronous lines.
// Assumes each line is stable for several clk cycles between changes.
module trw_sync_edge #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES:0] pipe;

        // Shift the line through the synchroniser, keeping one extra stage for edges
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= {(STAGES+1){RST_VAL[g]}};
            else        pipe <= {pipe[STAGES-1:0], din[g]};
        end

        assign lvl[g]  = pipe[STAGES-1];
        assign rise[g] = pipe[STAGES-1] & ~pipe[STAGES];
        assign fall[g] = ~pipe[STAGES-1] & pipe[STAGES];
    end
endmodule

// File: rtl/trw_frame_rx.sv
// Frame receiver: counts sampled bits and collects the address and data fields.
// Assumes strobe and clock edges arrive as single-cycle pulses in clk domain.
module trw_frame_rx
    import trw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strb_lvl,
    input  logic             strb_rise,
    input  logic             sclk_rise,
    input  logic             sdi_lvl,
    output addr_t            addr,
    output word_t            data,
    output logic [CNT_W-1:0] bit_cnt,
    output logic             full
);
    localparam int AIDX_W = $clog2(ADDR_W);
    localparam int DIDX_W = $clog2(WORD_W);

    logic [CNT_W-1:0] data_idx;
    assign data_idx = bit_cnt - CNT_W'(ADDR_W);
    assign full     = (bit_cnt == CNT_W'(FRAME_BITS));

    // Clear on frame start, then store one bit per rising serial clock until full
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            addr    <= '0;
            data    <= '0;
        end else if (strb_rise) begin
            bit_cnt <= '0;
            addr    <= '0;
            data    <= '0;
        end else if (strb_lvl && sclk_rise && !full) begin
            if (bit_cnt < CNT_W'(ADDR_W)) addr[bit_cnt[AIDX_W-1:0]] <= sdi_lvl;
            else                          data[data_idx[DIDX_W-1:0]] <= sdi_lvl;
            bit_cnt <= bit_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/trw_regfile.sv
// Control registers with commit at frame end, plus address decode and status-word assembly.
// Assumes the address field is complete once eight bits are counted.
module trw_regfile
    import trw_pkg::*;
#(
    parameter addr_t WR_A_ADDR = 8'hD0,
    parameter addr_t WR_B_ADDR = 8'hD2,
    parameter addr_t RD_A_ADDR = 8'hD1,
    parameter addr_t RD_B_ADDR = 8'hD3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_end,
    input  logic                 full,
    input  addr_t                addr,
    input  word_t                data,
    input  logic [CNT_FLD_W-1:0] gc_count,
    input  logic                 gc_over,
    input  logic                 gc_busy,
    input  logic                 lk_enable,
    input  logic                 lk_unlock,
    input  logic [PE_W-1:0]      lk_phase,
    input  logic [PIN_W-1:0]     pin_in,
    output word_t                cfg_a,
    output word_t                cfg_b,
    output logic                 rd_hit,
    output word_t                rd_word
);
    // Commit a complete write frame to the addressed control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_a <= CFG_A_RST;
            cfg_b <= CFG_B_RST;
        end else if (frame_end && full) begin
            if (addr == WR_A_ADDR) cfg_a <= data;
            if (addr == WR_B_ADDR) cfg_b <= data;
        end
    end

    // Decode read addresses and build the selected status word
    always_comb begin
        rd_hit = (addr == RD_A_ADDR) || (addr == RD_B_ADDR);
        if (addr == RD_A_ADDR)
            rd_word = {{CNT_PAD_W{1'b0}}, gc_busy, gc_over, gc_count};
        else
            rd_word = {pin_in, cfg_b[DIR_LSB+DIR_W+OUT_W-1:DIR_LSB],
                       {LK_GAP_W{1'b0}}, lk_phase, lk_unlock, lk_enable};
    end
endmodule

// File: rtl/trw_tx_shift.sv
// Read-data shifter: snapshots the status word after the address, then shifts on falling clocks.
// Assumes a well-formed frame; the driver enable drops at the last bit or frame end.
module trw_tx_shift
    import trw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strb_lvl,
    input  logic             strb_edge,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic             rd_hit,
    input  word_t            rd_word,
    output word_t            tx_shreg,
    output logic             tx_en
);
    // Load, shift and release the read word over the frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_shreg <= '0;
            tx_en    <= 1'b0;
        end else if (strb_edge) begin
            tx_en <= 1'b0;
        end else if (strb_lvl && sclk_rise && bit_cnt == CNT_W'(FRAME_BITS - 1)) begin
            tx_en <= 1'b0;
        end else if (strb_lvl && sclk_fall) begin
            if (!tx_en && rd_hit && bit_cnt == CNT_W'(ADDR_W)) begin
                tx_shreg <= rd_word;
                tx_en    <= 1'b1;
            end else if (tx_en && bit_cnt > CNT_W'(ADDR_W)) begin
                tx_shreg <= tx_shreg >> 1;
            end
        end
    end
endmodule

// File: rtl/tri_wire_regport.sv
// Top of the three-wire addressed register port: synchroniser, receiver, registers, read shifter.
// Assumes the pad's tristate driver sits outside, steered by ser_dout_en.
module tri_wire_regport
    import trw_pkg::*;
#(
    parameter int    SYNC_STAGES = 2,
    parameter addr_t WR_A_ADDR   = 8'hD0,
    parameter addr_t WR_B_ADDR   = 8'hD2,
    parameter addr_t RD_A_ADDR   = 8'hD1,
    parameter addr_t RD_B_ADDR   = 8'hD3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_strobe,
    input  logic                 ser_clk,
    input  logic                 ser_din,
    output logic                 ser_dout,
    output logic                 ser_dout_en,
    output logic [WORD_W-1:0]    cfg_a,
    output logic [WORD_W-1:0]    cfg_b,
    input  logic [CNT_FLD_W-1:0] gc_count,
    input  logic                 gc_over,
    input  logic                 gc_busy,
    input  logic                 lk_enable,
    input  logic                 lk_unlock,
    input  logic [PE_W-1:0]      lk_phase,
    input  logic [PIN_W-1:0]     pin_in
);
    logic [2:0]       s_lvl, s_rise, s_fall;
    logic             strb_s, sclk_rise, sclk_fall, frame_end, strb_rise, sdi_s;
    logic             full, rd_hit;
    logic [CNT_W-1:0] bit_cnt;
    addr_t            addr;
    word_t            data, rd_word, tx_shreg;
    logic             sync_unused;

    trw_sync_edge #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({ser_din, ser_clk, ser_strobe}),
        .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
    );

    assign strb_s      = s_lvl[0];
    assign strb_rise   = s_rise[0];
    assign frame_end   = s_fall[0];
    assign sclk_rise   = s_rise[1];
    assign sclk_fall   = s_fall[1];
    assign sdi_s       = s_lvl[2];
    assign sync_unused = ^{s_lvl[1], s_rise[2], s_fall[2]};

    trw_frame_rx u_rx (
        .clk(clk), .rst_n(rst_n), .strb_lvl(strb_s), .strb_rise(strb_rise),
        .sclk_rise(sclk_rise), .sdi_lvl(sdi_s),
        .addr(addr), .data(data), .bit_cnt(bit_cnt), .full(full)
    );

    trw_regfile #(
        .WR_A_ADDR(WR_A_ADDR), .WR_B_ADDR(WR_B_ADDR),
        .RD_A_ADDR(RD_A_ADDR), .RD_B_ADDR(RD_B_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .full(full),
        .addr(addr), .data(data),
        .gc_count(gc_count), .gc_over(gc_over), .gc_busy(gc_busy),
        .lk_enable(lk_enable), .lk_unlock(lk_unlock), .lk_phase(lk_phase), .pin_in(pin_in),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .rd_hit(rd_hit), .rd_word(rd_word)
    );

    trw_tx_shift u_tx (
        .clk(clk), .rst_n(rst_n), .strb_lvl(strb_s), .strb_edge(strb_rise | frame_end),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .bit_cnt(bit_cnt),
        .rd_hit(rd_hit), .rd_word(rd_word), .tx_shreg(tx_shreg), .tx_en(ser_dout_en)
    );

    assign ser_dout = tx_shreg[0];
endmodule

// File: rtl/trw_checker.sv
// Property checker for the three-wire register port, bound to the top module.
// Assumes internal edge pulses of the top are visible by name through the bind.
module trw_checker
    import trw_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             frm_act,
    input logic             sclk_fall,
    input logic             frame_end,
    input logic [CNT_W-1:0] bit_cnt,
    input logic [WORD_W-1:0] tx_shreg,
    input logic             ser_dout_en,
    input logic [WORD_W-1:0] cfg_a,
    input logic [WORD_W-1:0] cfg_b
);
    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> ($stable(cfg_a) && $stable(cfg_b)));

    // R5
    cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_BITS));

    // R9
    oe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_dout_en && !frame_end) |-> frm_act);

    // R9
    oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_dout_en) |-> $past(sclk_fall));

    // R7
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(tx_shreg));
endmodule

bind tri_wire_regport trw_checker u_trw_checker (
    .clk(clk), .rst_n(rst_n), .frm_act(strb_s), .sclk_fall(sclk_fall),
    .frame_end(frame_end), .bit_cnt(bit_cnt), .tx_shreg(tx_shreg),
    .ser_dout_en(ser_dout_en), .cfg_a(cfg_a), .cfg_b(cfg_b)
);

// File: tb/test_tri_wire_regport.sv
`timescale 1ns/1ps
module test_tri_wire_regport;
    localparam int H   = 4;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_strobe = 1'b0, ser_clk = 1'b1, ser_din = 1'b1;
    logic        ser_dout, ser_dout_en;
    logic [23:0] cfg_a, cfg_b;
    logic [19:0] gc_count = '0;
    logic        gc_over = 1'b0, gc_busy = 1'b0, lk_enable = 1'b0, lk_unlock = 1'b0;
    logic [2:0]  lk_phase = '0;
    logic [4:0]  pin_in = '0;

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic [23:0] m_a = 24'h0F0000, m_b = 24'h0;
    logic        m_en = 1'b0, m_sdo = 1'b0;
    int          m_cnt = 0;
    logic [7:0]  m_addr = '0;
    logic [23:0] m_data = '0, m_word = '0;

    logic [23:0] ha [0:LAT];
    logic [23:0] hb [0:LAT];
    logic        hen [0:LAT];
    logic        hsdo [0:LAT];

    tri_wire_regport #(.SYNC_STAGES(2)) i_tri_wire_regport (
        .clk(clk), .rst_n(rst_n), .ser_strobe(ser_strobe), .ser_clk(ser_clk),
        .ser_din(ser_din), .ser_dout(ser_dout), .ser_dout_en(ser_dout_en),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .gc_count(gc_count), .gc_over(gc_over),
        .gc_busy(gc_busy), .lk_enable(lk_enable), .lk_unlock(lk_unlock),
        .lk_phase(lk_phase), .pin_in(pin_in)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    function automatic logic [23:0] word_d1();
        return {2'b00, gc_busy, gc_over, gc_count};
    endfunction

    function automatic logic [23:0] word_d3();
        return {pin_in, m_b[18:10], 5'b00000, lk_phase, lk_unlock, lk_enable};
    endfunction

    // R10: compare outputs every clock with the model delayed by LAT cycles
    initial begin
        for (int i = 0; i <= LAT; i++) begin
            ha[i] = 24'h0F0000; hb[i] = '0; hen[i] = 1'b0; hsdo[i] = 1'b0;
        end
    end

    always @(negedge clk) begin
        for (int i = LAT; i > 0; i--) begin
            ha[i] = ha[i-1]; hb[i] = hb[i-1]; hen[i] = hen[i-1]; hsdo[i] = hsdo[i-1];
        end
        ha[0] = m_a; hb[0] = m_b; hen[0] = m_en; hsdo[0] = m_sdo;
        if (rst_n) begin
            chk("R10", "cfg_a per clock", {8'h0, cfg_a}, {8'h0, ha[LAT]});
            chk("R10", "cfg_b per clock", {8'h0, cfg_b}, {8'h0, hb[LAT]});
            chk("R10", "dout_en per clock", {31'h0, ser_dout_en}, {31'h0, hen[LAT]});
            if (hen[LAT]) chk("R10", "dout per clock", {31'h0, ser_dout}, {31'h0, hsdo[LAT]});
        end
    end

    // one frame: nbits clocks, optional status change after bit perturb_at
    task automatic do_frame(input logic [7:0] a, input logic [23:0] d, input int nbits,
                            input int perturb_at, output logic [23:0] rx);
        rx = '0;
        ser_strobe = 1'b1;
        m_cnt = 0; m_en = 1'b0; m_addr = '0; m_data = '0;
        tick(H);
        for (int i = 0; i < nbits; i++) begin
            logic b;
            b = (i < 8) ? a[i] : ((i < 32) ? d[i-8] : 1'b1);
            ser_clk = 1'b0; ser_din = b;
            if (m_cnt == 8 && (m_addr == 8'hD1 || m_addr == 8'hD3) && !m_en) begin
                m_word = (m_addr == 8'hD1) ? word_d1() : word_d3();
                m_en = 1'b1; m_sdo = m_word[0];
            end else if (m_en && m_cnt > 8) begin
                m_word = m_word >> 1; m_sdo = m_word[0];
            end
            tick(H);
            if (i >= 8 && i < 32) begin
                rx[i-8] = ser_dout;
                chk("R9", "dout_en during data", {31'h0, ser_dout_en}, {31'h0, m_en});
            end
            ser_clk = 1'b1;
            if (m_cnt < 32) begin
                if (m_cnt < 8) m_addr[m_cnt] = b; else m_data[m_cnt-8] = b;
                m_cnt++;
                if (m_cnt == 32) m_en = 1'b0;
            end
            if (i == perturb_at) begin
                gc_count = ~gc_count; gc_over = ~gc_over; gc_busy = ~gc_busy;
                lk_enable = ~lk_enable; pin_in = ~pin_in;
            end
            tick(H);
        end
        ser_strobe = 1'b0; ser_din = 1'b1;
        if (m_cnt == 32) begin
            if (m_addr == 8'hD0) m_a = m_data;
            if (m_addr == 8'hD2) m_b = m_data;
        end
        m_en = 1'b0;
        tick(3 * H);
    endtask

    task automatic run_all();
        logic [23:0] rx, exp;
        tick(4);
        rst_n = 1'b1;
        tick(4);
        // R1
        chk("R1", "cfg_a reset", {8'h0, cfg_a}, 32'h000F0000);
        chk("R1", "cfg_b reset", {8'h0, cfg_b}, 32'h0);
        chk("R1", "dout_en reset", {31'h0, ser_dout_en}, 32'h0);

        // R2 R3: full writes to both control registers
        do_frame(8'hD0, 24'h123456, 32, -1, rx);
        chk("R3", "cfg_a after write", {8'h0, cfg_a}, 32'h00123456);
        do_frame(8'hD2, 24'hABCDEF, 32, -1, rx);
        chk("R2", "cfg_b after write", {8'h0, cfg_b}, 32'h00ABCDEF);
        chk("R3", "cfg_a untouched by D2 write", {8'h0, cfg_a}, 32'h00123456);

        // R4: short frame commits nothing
        do_frame(8'hD0, 24'hFFFFFF, 20, -1, rx);
        chk("R4", "cfg_a after short frame", {8'h0, cfg_a}, 32'h00123456);

        // R5: overlong frame keeps the first 24 data bits
        do_frame(8'hD2, 24'h5A5A5A, 36, -1, rx);
        chk("R5", "cfg_b after 36-bit frame", {8'h0, cfg_b}, 32'h005A5A5A);

        // R6: unknown address and a write to a read address
        do_frame(8'hD4, 24'h777777, 32, -1, rx);
        chk("R6", "cfg_a after unknown addr", {8'h0, cfg_a}, 32'h00123456);
        chk("R6", "cfg_b after unknown addr", {8'h0, cfg_b}, 32'h005A5A5A);
        do_frame(8'hD1, 24'h333333, 32, -1, rx);
        chk("R6", "cfg_a after write to D1", {8'h0, cfg_a}, 32'h00123456);
        chk("R6", "cfg_b after write to D1", {8'h0, cfg_b}, 32'h005A5A5A);

        // R7: count word read
        gc_count = 20'hABCDE; gc_over = 1'b1; gc_busy = 1'b0;
        exp = word_d1();
        do_frame(8'hD1, 24'hFFFFFF, 32, -1, rx);
        chk("R7", "D1 word", {8'h0, rx}, {8'h0, exp});
        gc_count = 20'h00F01; gc_over = 1'b0; gc_busy = 1'b1;
        exp = word_d1();
        do_frame(8'hD1, 24'hFFFFFF, 32, -1, rx);
        chk("R7", "D1 word busy", {8'h0, rx}, {8'h0, exp});

        // R8: lock and port word read, with a distinct cfg_b pattern
        do_frame(8'hD2, 24'h13A400, 32, -1, rx);
        lk_enable = 1'b1; lk_unlock = 1'b0; lk_phase = 3'b101; pin_in = 5'b10011;
        exp = word_d3();
        do_frame(8'hD3, 24'hFFFFFF, 32, -1, rx);
        chk("R8", "D3 word", {8'h0, rx}, {8'h0, exp});

        // R11: status change after capture does not leak into the shifted word
        gc_count = 20'h5A5A5; gc_over = 1'b0; gc_busy = 1'b0;
        exp = word_d1();
        do_frame(8'hD1, 24'hFFFFFF, 32, 12, rx);
        chk("R11", "D1 word frozen", {8'h0, rx}, {8'h0, exp});

        // R9: aborted read releases the driver at frame end
        do_frame(8'hD3, 24'hFFFFFF, 16, -1, rx);
        chk("R9", "dout_en after aborted read", {31'h0, ser_dout_en}, 32'h0);
        chk("R4", "cfg_b after aborted read", {8'h0, cfg_b}, 32'h0013A400);
        tick(8);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                checks++; fails++;
                $display("FAIL R10 watchdog actual=timeout expected=finish");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule